// File: doc/BRIEF.md
# Serial Frame Engine, Clock-Low Idle, Sample-on-Rise

This block moves words between parallel FIFO-style interfaces and a four-wire synchronous serial link. It uses clock polarity 0 and phase 0: the serial clock rests low, data is captured on rising edges and changed on falling edges. As master it takes words from a transmit FIFO port and generates the serial clock, an active-low frame select and the transmit data. Every received word is returned through a receive FIFO port. As slave it follows an external clock and frame select, which are brought in through synchronizers.

The word length can be set from 4 to 16 bits. The serial clock is an even division of the system clock. While the transmit FIFO still has data, frames follow each other, and frame select goes high for one serial period between them. Two active-low pad enables go with the outputs. One switches the transmit data pad, so it is high impedance when no frame is running. The other switches the clock pad, so only a master drives the clock.

Top module: `spi0_frame_engine`

## Requirements
- R1: The word length is taken from `cfg_bits`: a value below 4 means 4, a value above 16 means 16. The length is captured when a frame starts. Transmit words are right-aligned in `tx_data`, and bits above the word length are ignored.
- R2: Data goes out most significant bit first. The first bit is on `txd` from the cycle in which frame select falls. The next bit appears together with each falling serial clock edge. Master `rxd` is captured in the system cycle in which the serial clock rises.
- R3: With H = `cfg_half` (0 counts as 1), each serial clock half period lasts H system cycles. The first rising edge comes H cycles after frame select falls, so a frame of N bits keeps frame select low for 2·N·H cycles.
- R4: When no frame runs in master mode, the outputs rest at `sclk_out`=0, `fss_n_out`=1, `txd`=0 and `txd_oe_n`=1. Whenever `txd_oe_n` is 1, `txd` is 0.
- R5: `sclk_oe_n` is 0 in master mode and 1 in slave mode.
- R6: A master frame starts only when `cfg_enable`=1, `cfg_slave`=0 and `tx_valid`=1. The word is taken with a one-cycle `tx_pop` pulse. In the next cycle, `fss_n_out` and `txd_oe_n` go low. With `cfg_enable`=0 a waiting word stays in the FIFO.
- R7: After a frame, `fss_n_out` is high for exactly 2·H cycles while `txd_oe_n` stays low. A waiting word then starts at once. Otherwise the block returns to rest.
- R8: `rx_push` is a one-cycle pulse in the cycle in which the last bit is captured. `rx_data` then holds the received word in its low N bits, with zeros above.
- R9: In slave mode, `sclk_in`, `fss_n_in` and `rxd` pass through synchronizers. Clock edges are ignored while frame select is high. A falling frame select pops a word, or sends zeros when the FIFO is empty. `rx_push` follows the Nth synchronized rising edge. `txd_oe_n` is low only while the block is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Allows transfers |
| cfg_slave | input | 1 | 1 = slave mode, 0 = master mode |
| cfg_bits | input | 5 | Requested word length |
| cfg_half | input | 8 | Serial half period in system cycles |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_data | input | 16 | Head word of the transmit FIFO, right-aligned |
| tx_pop | output | 1 | Takes the head word |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_data | output | 16 | Received word, right-aligned |
| sclk_out | output | 1 | Serial clock (master) |
| sclk_in | input | 1 | Serial clock from a master (slave) |
| fss_n_out | output | 1 | Active-low frame select (master) |
| fss_n_in | input | 1 | Active-low frame select from a master (slave) |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| txd_oe_n | output | 1 | Active-low transmit data pad enable |
| sclk_oe_n | output | 1 | Active-low clock pad enable |

## Verification
The bench uses the default build: a 16-bit word ceiling, an 8-bit divider and two synchronizer stages. Through the ports it sweeps half periods of 0, 1, 2 and 3, and word lengths requested as 2, 5, 8 and 20. This covers both clamp limits, single-cycle clock phases and odd word lengths. In master mode, `rxd` is looped back from `txd`, either straight or inverted, so every received bit can be predicted from the transmitted word. In slave mode, the bench drives a slow external clock with six-cycle phases, which is long enough to absorb the synchronizer delay.

// File: rtl/spi0_pkg.sv
package spi0_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HI,
    PH_LO,
    PH_GAP
  } phase_e;

  localparam int MIN_WORD = 4;

  function automatic int clamp_len(int req, int hi);
    if (req < MIN_WORD) return MIN_WORD;
    if (req > hi) return hi;
    return req;
  endfunction

  function automatic int half_cycles(int div);
    return (div < 1) ? 1 : div;
  endfunction

endpackage

// File: rtl/spi0_sync_bit.sv
module spi0_sync_bit #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{INIT}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi0_master_seq.sv
module spi0_master_seq
  import spi0_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int DIV_W    = 8,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic [LEN_W-1:0]    cfg_bits,
  input  logic [DIV_W-1:0]    cfg_half,
  input  logic                tx_valid,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                tx_pop,
  input  logic                rxd,
  output logic                rx_push,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                sclk,
  output logic                fss_n,
  output logic                txd,
  output logic                txd_oe_n
);
  localparam int CNT_W = DIV_W + 1;
  localparam int GAP_W = CNT_W + 1;

  phase_e              ph;
  logic [CNT_W-1:0]    cnt;
  logic [LEN_W-1:0]    bidx, nlen;
  logic [DIV_W-1:0]    hlat;
  logic [MAX_BITS-1:0] tx_sh;
  logic [MAX_BITS-2:0] rx_sh;

  logic [LEN_W-1:0]    req_len;
  logic [DIV_W-1:0]    req_half;
  logic                cnt_done, last_bit, in_frame, start_ev, rise_ev, fall_ev;
  logic [MAX_BITS-1:0] rx_word, len_mask;
  logic [CNT_W-1:0]    half_m1, gap_m1;

  assign req_len  = LEN_W'(clamp_len(int'(cfg_bits), MAX_BITS));
  assign req_half = DIV_W'(half_cycles(int'(cfg_half)));
  assign cnt_done = (cnt == '0);
  assign last_bit = (bidx == nlen - LEN_W'(1));
  assign in_frame = (ph == PH_SETUP) || (ph == PH_HI) || (ph == PH_LO);
  assign start_ev = run_en && tx_valid && ((ph == PH_IDLE) || ((ph == PH_GAP) && cnt_done));
  assign rise_ev  = cnt_done && ((ph == PH_SETUP) || (ph == PH_LO));
  assign fall_ev  = cnt_done && (ph == PH_HI) && !last_bit;
  assign rx_word  = {rx_sh, rxd};
  assign len_mask = ~({MAX_BITS{1'b1}} << nlen);
  assign half_m1  = CNT_W'(hlat) - CNT_W'(1);
  assign gap_m1   = {hlat, 1'b0} - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      nlen    <= LEN_W'(MIN_WORD);
      hlat    <= DIV_W'(1);
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_push <= 1'b0;
      rx_data <= '0;
    end else begin
      rx_push <= 1'b0;
      if (start_ev) begin
        ph    <= PH_SETUP;
        cnt   <= CNT_W'(req_half) - CNT_W'(1);
        bidx  <= '0;
        nlen  <= req_len;
        hlat  <= req_half;
        tx_sh <= tx_data << (LEN_W'(MAX_BITS) - req_len);
      end else if (rise_ev) begin
        ph    <= PH_HI;
        cnt   <= half_m1;
        rx_sh <= rx_word[MAX_BITS-2:0];
        if (last_bit) begin
          rx_push <= 1'b1;
          rx_data <= rx_word & len_mask;
        end
      end else if (fall_ev) begin
        ph    <= PH_LO;
        cnt   <= half_m1;
        tx_sh <= tx_sh << 1;
        bidx  <= bidx + LEN_W'(1);
      end else if (cnt_done && (ph == PH_HI)) begin
        ph  <= PH_GAP;
        cnt <= gap_m1;
      end else if (cnt_done && (ph == PH_GAP)) begin
        ph <= PH_IDLE;
      end else if (ph != PH_IDLE) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign tx_pop   = start_ev;
  assign sclk     = (ph == PH_HI);
  assign fss_n    = !in_frame;
  assign txd      = in_frame && tx_sh[MAX_BITS-1];
  assign txd_oe_n = (ph == PH_IDLE);

  // Checker state: length of the last high stretch of frame select.
  logic [GAP_W-1:0] gap_cnt;
  logic             seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (!fss_n) seen_q <= 1'b1;
      if (!fss_n) gap_cnt <= '0;
      else if (gap_cnt != {GAP_W{1'b1}}) gap_cnt <= gap_cnt + GAP_W'(1);
    end
  end

  assert_pop_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (run_en && tx_valid));
  assert_start_after_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fss_n) |-> $past(tx_pop));
  assert_clock_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !fss_n);
  assert_gap_long_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fss_n) && seen_q) |-> (gap_cnt >= {1'b0, $past(hlat), 1'b0}));
  assert_push_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $rose(sclk));
endmodule

// File: rtl/spi0_slave_port.sv
module spi0_slave_port
  import spi0_pkg::*;
#(
  parameter int MAX_BITS    = 16,
  parameter int LEN_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic [LEN_W-1:0]    cfg_bits,
  input  logic                tx_valid,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                tx_pop,
  input  logic                sclk_in,
  input  logic                fss_n_in,
  input  logic                rxd,
  output logic                rx_push,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                txd,
  output logic                txd_oe_n
);
  localparam int          N_SYNC    = 3;
  localparam logic [2:0]  SYNC_INIT = 3'b010;  // {rxd, fss_n, sclk}

  logic [N_SYNC-1:0] raw_in, synced;
  assign raw_in = {rxd, fss_n_in, sclk_in};

  for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_sync
    spi0_sync_bit #(.STAGES(SYNC_STAGES), .INIT(SYNC_INIT[gi])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in[gi]), .q(synced[gi])
    );
  end

  logic sclk_s, fss_s, rxd_s, sclk_d, fss_d;
  assign sclk_s = synced[0];
  assign fss_s  = synced[1];
  assign rxd_s  = synced[2];

  logic                r_edge, f_edge, sel, sel_fall, drive;
  logic [LEN_W-1:0]    cnt, nlen, req_len;
  logic [MAX_BITS-1:0] tx_sh, rx_word, len_mask;
  logic [MAX_BITS-2:0] rx_sh;

  assign r_edge   = sclk_s && !sclk_d;
  assign f_edge   = !sclk_s && sclk_d;
  assign sel      = !fss_s;
  assign sel_fall = !fss_s && fss_d;
  assign req_len  = LEN_W'(clamp_len(int'(cfg_bits), MAX_BITS));
  assign rx_word  = {rx_sh, rxd_s};
  assign len_mask = ~({MAX_BITS{1'b1}} << nlen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      fss_d   <= 1'b1;
      drive   <= 1'b0;
      cnt     <= '0;
      nlen    <= LEN_W'(MIN_WORD);
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_push <= 1'b0;
      rx_data <= '0;
    end else begin
      sclk_d  <= sclk_s;
      fss_d   <= fss_s;
      rx_push <= 1'b0;
      if (!run_en || !sel) drive <= 1'b0;
      if (run_en && sel_fall) begin
        drive <= 1'b1;
        cnt   <= '0;
        nlen  <= req_len;
        tx_sh <= tx_valid ? (tx_data << (LEN_W'(MAX_BITS) - req_len)) : '0;
      end else if (drive && sel) begin
        if (r_edge) begin
          rx_sh <= rx_word[MAX_BITS-2:0];
          if (cnt == nlen - LEN_W'(1)) begin
            rx_push <= 1'b1;
            rx_data <= rx_word & len_mask;
            cnt     <= '0;
          end else begin
            cnt <= cnt + LEN_W'(1);
          end
        end
        if (f_edge) tx_sh <= tx_sh << 1;
      end
    end
  end

  assign tx_pop   = run_en && sel_fall && tx_valid;
  assign txd      = drive && tx_sh[MAX_BITS-1];
  assign txd_oe_n = !drive;

  assert_push_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fss_s) |-> !rx_push);
  assert_pop_on_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> ($past(fss_s) && !fss_s));
endmodule

// File: rtl/spi0_frame_engine.sv
module spi0_frame_engine #(
  parameter  int MAX_BITS    = 16,
  parameter  int DIV_W       = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int LEN_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic                cfg_slave,
  input  logic [LEN_W-1:0]    cfg_bits,
  input  logic [DIV_W-1:0]    cfg_half,
  input  logic                tx_valid,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                tx_pop,
  output logic                rx_push,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                sclk_out,
  input  logic                sclk_in,
  output logic                fss_n_out,
  input  logic                fss_n_in,
  input  logic                rxd,
  output logic                txd,
  output logic                txd_oe_n,
  output logic                sclk_oe_n
);
  logic                m_pop, m_push, m_txd, m_oe_n, s_pop, s_push, s_txd, s_oe_n;
  logic [MAX_BITS-1:0] m_data, s_data;

  spi0_master_seq #(.MAX_BITS(MAX_BITS), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_master (
    .clk(clk), .rst_n(rst_n), .run_en(cfg_enable && !cfg_slave),
    .cfg_bits(cfg_bits), .cfg_half(cfg_half),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(m_pop),
    .rxd(rxd), .rx_push(m_push), .rx_data(m_data),
    .sclk(sclk_out), .fss_n(fss_n_out), .txd(m_txd), .txd_oe_n(m_oe_n)
  );

  spi0_slave_port #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .SYNC_STAGES(SYNC_STAGES)) u_slave (
    .clk(clk), .rst_n(rst_n), .run_en(cfg_enable && cfg_slave),
    .cfg_bits(cfg_bits),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(s_pop),
    .sclk_in(sclk_in), .fss_n_in(fss_n_in), .rxd(rxd),
    .rx_push(s_push), .rx_data(s_data), .txd(s_txd), .txd_oe_n(s_oe_n)
  );

  assign tx_pop    = m_pop || s_pop;
  assign rx_push   = m_push || s_push;
  assign rx_data   = cfg_slave ? s_data : m_data;
  assign txd       = cfg_slave ? s_txd : m_txd;
  assign txd_oe_n  = cfg_slave ? s_oe_n : m_oe_n;
  assign sclk_oe_n = cfg_slave;

  assert_pad_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txd_oe_n |-> !txd);
  assert_single_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_push, s_push}));
endmodule

// File: tb/test_spi0_frame_engine.sv
module test_spi0_frame_engine;
  localparam int HS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_slave = 1'b0;
  logic [4:0]  cfg_bits = 5'd8;
  logic [7:0]  cfg_half = 8'd1;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic        tx_pop, rx_push, sclk_out, fss_n_out, txd, txd_oe_n, sclk_oe_n;
  logic [15:0] rx_data;
  logic        sclk_in = 1'b0, fss_n_in = 1'b1, rxd_drv = 1'b0, loop_inv = 1'b0;
  logic        rxd;

  assign rxd = cfg_slave ? rxd_drv : (txd ^ loop_inv);

  always #10 clk = ~clk;

  spi0_frame_engine i_spi0_frame_engine (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_slave(cfg_slave),
    .cfg_bits(cfg_bits), .cfg_half(cfg_half), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .sclk_out(sclk_out),
    .sclk_in(sclk_in), .fss_n_out(fss_n_out), .fss_n_in(fss_n_in), .rxd(rxd),
    .txd(txd), .txd_oe_n(txd_oe_n), .sclk_oe_n(sclk_oe_n)
  );

  int errors = 0, checks = 0;
  logic [15:0] q[$];
  bit model_on = 1'b0;
  int m_mode = 0, m_t = 0, m_g = 0, m_n = 8, m_h = 1;
  logic [15:0] m_word = 16'h0;
  int m_cnt = 0, s_cnt = 0;
  logic [15:0] m_last = 16'h0, s_last = 16'h0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int word_len(int b);
    int n = b;
    if (n > 16) n = 16;
    if (n < 4) n = 4;
    return n;
  endfunction

  function automatic int half_len(int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic bit can_start();
    return cfg_enable && !cfg_slave && tx_valid;
  endfunction

  // Reference model: advances on the rising edge, drives the FIFO head afterwards.
  always @(posedge clk) begin
    if (rst_n) begin
      if (rx_push) begin
        if (cfg_slave) begin s_cnt++; s_last = rx_data; end
        else begin m_cnt++; m_last = rx_data; end
      end
      if (m_mode == 0) begin
        if (can_start()) begin
          m_mode = 1; m_t = 0; m_n = word_len(int'(cfg_bits)); m_h = half_len(int'(cfg_half));
          m_word = tx_data; void'(q.pop_front());
        end
      end else if (m_mode == 1) begin
        m_t++;
        if (m_t == 2 * m_n * m_h) begin m_mode = 2; m_g = 0; end
      end else begin
        m_g++;
        if (m_g == 2 * m_h) begin
          if (can_start()) begin
            m_mode = 1; m_t = 0; m_n = word_len(int'(cfg_bits)); m_h = half_len(int'(cfg_half));
            m_word = tx_data; void'(q.pop_front());
          end else m_mode = 0;
        end
      end
      if (cfg_slave && tx_pop) void'(q.pop_front());
    end
    #2;
    tx_valid = (q.size() > 0);
    tx_data  = tx_valid ? q[0] : 16'h0;
  end

  // Compare on the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (model_on) begin
      int p, e_sclk, e_fss, e_txd, e_oe, e_pop, e_push, e_data;
      string tg;
      e_sclk = 0; e_fss = 1; e_txd = 0; e_oe = 1; e_push = 0; e_data = 0;
      e_pop = can_start() ? 1 : 0;
      tg = "R4 rest";
      if (m_mode == 1) begin
        p = m_t / m_h;
        e_sclk = p % 2; e_fss = 0; e_oe = 0; e_pop = 0;
        e_txd = int'(m_word[m_n - 1 - p / 2]);
        e_push = (m_t == (2 * m_n - 1) * m_h) ? 1 : 0;
        e_data = int'(loop_inv ? ~m_word : m_word) & ((1 << m_n) - 1);
        tg = "R3/R2 frame";
      end else if (m_mode == 2) begin
        e_oe = 0;
        e_pop = ((m_g == 2 * m_h - 1) && can_start()) ? 1 : 0;
        tg = "R7 gap";
      end
      chk(sclk_out == e_sclk[0], {tg, " sclk R3"}, int'(sclk_out), e_sclk);
      chk(fss_n_out == e_fss[0], {tg, " fss R6"}, int'(fss_n_out), e_fss);
      chk(sclk_oe_n == cfg_slave, "R5 clock pad enable", int'(sclk_oe_n), int'(cfg_slave));
      if (!cfg_slave) begin
        chk(txd == e_txd[0], {tg, " txd R2"}, int'(txd), e_txd);
        chk(txd_oe_n == e_oe[0], {tg, " oe R4"}, int'(txd_oe_n), e_oe);
        chk(tx_pop == e_pop[0], {tg, " pop R6"}, int'(tx_pop), e_pop);
        chk(rx_push == e_push[0], {tg, " push R8"}, int'(rx_push), e_push);
        if (e_push == 1) chk(int'(rx_data) == e_data, "R8 rx word", int'(rx_data), e_data);
      end
    end
  end

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    step(1);
    while (!(m_mode == 0 && q.size() == 0)) step(1);
    step(4);
  endtask

  task automatic slave_frame(input logic [15:0] mo, input int n, output logic [15:0] got);
    got = 16'h0;
    step(1);
    fss_n_in = 1'b0;
    rxd_drv = mo[n-1];
    for (int i = 0; i < n; i++) begin
      step(HS);
      if (i == 0) chk(txd_oe_n == 1'b0, "R9 pad on while selected", int'(txd_oe_n), 0);
      got = {got[14:0], txd};
      sclk_in = 1'b1;
      step(HS);
      sclk_in = 1'b0;
      if (i < n - 1) rxd_drv = mo[n-2-i];
    end
    step(HS);
    fss_n_in = 1'b1;
    step(HS);
  endtask

  initial begin
    logic [15:0] got;
    int sc;
    step(3);
    @(negedge clk);
    chk(sclk_out == 1'b0, "R4 reset sclk", int'(sclk_out), 0);
    chk(fss_n_out == 1'b1, "R4 reset fss", int'(fss_n_out), 1);
    chk(txd == 1'b0, "R4 reset txd", int'(txd), 0);
    chk(txd_oe_n == 1'b1, "R4 reset pad", int'(txd_oe_n), 1);
    chk(sclk_oe_n == 1'b0, "R5 reset clock pad", int'(sclk_oe_n), 0);
    chk(rx_push == 1'b0 && tx_pop == 1'b0, "R6 reset strobes", int'({rx_push, tx_pop}), 0);
    step(1);
    rst_n = 1'b1;
    model_on = 1'b1;
    step(2);

    // Master, 8 bits, shortest clock, two words back to back.
    cfg_enable = 1'b1;
    q.push_back(16'h00A5); q.push_back(16'h003C);
    drain();
    chk(m_last == 16'h003C, "R7 second word received", int'(m_last), 16'h3C);

    // Length clamped up to 4, half period 3, inverted loopback, high bits ignored.
    cfg_bits = 5'd2; cfg_half = 8'd3; loop_inv = 1'b1;
    q.push_back(16'hFFF9); q.push_back(16'h0006);
    drain();
    chk(m_last == 16'h0009, "R1 clamp to 4 bits", int'(m_last), 16'h9);

    // Length clamped down to 16, half period 0 counts as 1.
    cfg_bits = 5'd20; cfg_half = 8'd0; loop_inv = 1'b0;
    q.push_back(16'h8001); q.push_back(16'h7FFE); q.push_back(16'h1234);
    drain();
    chk(m_last == 16'h1234, "R1 clamp to 16 bits", int'(m_last), 16'h1234);

    // Disabled: a waiting word is not taken.
    cfg_enable = 1'b0; cfg_bits = 5'd5; cfg_half = 8'd2;
    q.push_back(16'h0015);
    step(40);
    chk(q.size() == 1, "R6 disabled keeps word", q.size(), 1);
    chk(fss_n_out == 1'b1, "R6 disabled no frame", int'(fss_n_out), 1);
    cfg_enable = 1'b1;
    drain();
    chk(m_last == 16'h0015, "R1 odd length 5", int'(m_last), 16'h15);
    chk(m_cnt == 8, "R8 one push per master word", m_cnt, 8);

    // Slave mode.
    cfg_slave = 1'b1; cfg_bits = 5'd8;
    step(3);
    q.push_back(16'h00C3);
    step(2);
    slave_frame(16'h005A, 8, got);
    chk(got == 16'h00C3, "R9 slave sends MSB first", int'(got), 16'hC3);
    chk(s_cnt == 1 && s_last == 16'h005A, "R9 slave receive", int'(s_last), 16'h5A);
    chk(txd_oe_n == 1'b1, "R9 pad off when deselected", int'(txd_oe_n), 1);

    sc = s_cnt;
    for (int i = 0; i < 6; i++) begin
      sclk_in = 1'b1; step(4); sclk_in = 1'b0; step(4);
    end
    chk(s_cnt == sc, "R9 edges ignored while deselected", s_cnt, sc);
    chk(txd_oe_n == 1'b1, "R9 pad stays off", int'(txd_oe_n), 1);

    cfg_bits = 5'd12;
    q.push_back(16'h0ABC);
    step(2);
    slave_frame(16'h03F1, 12, got);
    chk(got == 16'h0ABC, "R9 slave 12-bit send", int'(got), 16'hABC);
    chk(s_cnt == sc + 1 && s_last == 16'h03F1, "R9 slave 12-bit receive", int'(s_last), 16'h3F1);

    slave_frame(16'h0F0F, 12, got);
    chk(got == 16'h0000, "R9 empty FIFO sends zeros", int'(got), 0);
    chk(s_last == 16'h0F0F, "R9 receive during underrun", int'(s_last), 16'hF0F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule